// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static memory with registered inputs and outputs. A new read or write command can be issued on every enabled clock, in any mix, with no idle cycle between a read and a write. The data phase of both reads and writes falls on the second enabled clock after the command. A read issued right after a write to the same location therefore cannot see that data in the array yet, so the newest data is forwarded lane by lane.

Commands are qualified by three chip enables, a clock enable that freezes the whole pipeline, and an advance/load control. The advance/load control either loads a new address or steps a two-bit burst offset in linear or interleaved order. The shared data bus is split into an input, an output and an output-enable port. The output driver is gated by an asynchronous active-low output enable and is also forced off whenever no read data is being presented.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high and after it falls, `dq_oe` is low until a read command reaches its data phase.
- R2: A read command taken on enabled edge k presents the stored word on `dq_out`, with `dq_oe` high if `oe_n` is low, from enabled edge k+2 until the next enabled edge.
- R3: For a write command taken on enabled edge k, `dq_in` is sampled on enabled edge k+2.
- R4: The word is split into 9-bit lanes, lane i being bits [9i+8:9i]. A low `bsel_n[i]` writes lane i, and a high `bsel_n[i]` leaves the stored lane i unchanged.
- R5: A load (`adv_ld` low) is a command only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. Otherwise the cycle is a deselect: nothing is written and nothing is driven in its data phase.
- R6: While `cken_n` is high, no input is taken, `dq_out` holds its value and the pipeline state is kept. A stall never deselects the block.
- R7: `dq_oe` is low whenever `oe_n` is high, at any time.
- R8: `dq_oe` is low during the data phase of a write, during the data phase that follows a deselect, and while deselected.
- R9: Reads and writes to the same or different addresses may alternate on consecutive enabled clocks. A read always returns the newest value, with lanes merged from writes still in flight.
- R10: With `adv_ld` high, the block repeats the previous command type at the next burst address. The low two address bits are base+n mod 4 when `burst_lin` is 1 and base XOR n when it is 0. An advance after a deselect is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of control state |
| addr | input | ADDR_W | Word address used on a load |
| we_n | input | 1 | Low: write command, high: read command |
| bsel_n | input | LANES | Active-low lane write selects |
| adv_ld | input | 1 | High: advance burst, low: load new command |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Active-low chip enable |
| cken_n | input | 1 | Active-low clock enable, high stalls |
| oe_n | input | 1 | Asynchronous active-low output enable |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| dq_in | input | LANES*LANE_W | Write data from the shared bus |
| dq_out | output | LANES*LANE_W | Read data to the shared bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The collision that matters most is a write finishing its data phase on the same edge as a younger read to the same address is fetching from the array. The fetch is read-first, so only the lane merge on the following edge can give the right result. The bench provokes this with a write immediately followed by a read of that address, and with partial-lane writes interleaved with reads. Random mixed traffic adds stalls and deselects that move the two operations relative to each other. Each presented word and each driver-enable state is compared against a sequential reference memory that applies writes in command order.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_ctr.sv
`timescale 1ns/1ps
// Holds the loaded base address and a burst offset; produces the address of
// the command currently in the first pipeline stage.
module zt_burst_ctr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] low;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= ld_addr;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (linear) low = base_q[BURST_W-1:0] + cnt_q;
    else        low = base_q[BURST_W-1:0] ^ cnt_q;
  end

  assign cur_addr = {base_q[ADDR_W-1:BURST_W], low};
endmodule

// File: rtl/zt_cmd_pipe.sv
`timescale 1ns/1ps
// Command decode and the two command stages between command and data phase.
module zt_cmd_pipe
  import zt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we_n,
  input  logic              adv_ld,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              linear,
  input  logic [LANES-1:0]  bsel_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_bsel_n
);
  logic             chip_sel;
  logic             do_load;
  logic             do_step;
  op_e              nxt_op;
  logic [LANES-1:0] s1_bsel_n;

  assign chip_sel = !ce1_n && ce2 && !ce3_n;
  assign do_load  = !adv_ld && chip_sel;
  assign do_step  = adv_ld && (s1_op != OP_IDLE);

  always_comb begin
    if (!adv_ld) nxt_op = chip_sel ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
    else         nxt_op = s1_op;
  end

  zt_burst_ctr #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) i_burst (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (do_load),
    .step     (do_step),
    .linear   (linear),
    .ld_addr  (addr),
    .cur_addr (s1_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op     <= OP_IDLE;
      s2_op     <= OP_IDLE;
      s1_bsel_n <= '1;
      s2_bsel_n <= '1;
      s2_addr   <= '0;
    end else if (en) begin
      s1_op     <= nxt_op;
      s1_bsel_n <= bsel_n;
      s2_op     <= s1_op;
      s2_addr   <= s1_addr;
      s2_bsel_n <= s1_bsel_n;
    end
  end
endmodule

// File: rtl/zt_lane_ram.sv
`timescale 1ns/1ps
// Lane-enabled array with a registered read-first port, in a form suited to
// block RAM inference.
module zt_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [LANES-1:0][LANE_W-1:0]  rd_q,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [LANES-1:0]              wr_lane,
  input  logic [LANES-1:0][LANE_W-1:0]  wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_en && wr_lane[i]) mem[wr_addr][i] <= wr_data[i];
      end
      rd_q <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we_n,
  input  logic [LANES-1:0]         bsel_n,
  input  logic                     adv_ld,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     cken_n,
  input  logic                     oe_n,
  input  logic                     burst_lin,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic                          en;
  op_e                           s1_op;
  op_e                           s2_op;
  logic [ADDR_W-1:0]             s1_addr;
  logic [ADDR_W-1:0]             s2_addr;
  logic [LANES-1:0]              s2_bsel_n;
  logic [LANES-1:0][LANE_W-1:0]  ram_q;
  logic [LANES-1:0][LANE_W-1:0]  wdata;
  logic                          wr_now;

  // last committed write, used to patch the read-first array output
  logic                          fw_vld;
  logic [ADDR_W-1:0]             fw_addr;
  logic [LANES-1:0]              fw_lane;
  logic [LANES-1:0][LANE_W-1:0]  fw_data;
  logic                          fw_hit;
  logic [LANES-1:0][LANE_W-1:0]  merged;

  logic [DATA_W-1:0]             out_q;
  logic                          drv_q;

  assign en     = !cken_n;
  assign wdata  = dq_in;
  assign wr_now = en && (s2_op == OP_WR);

  zt_cmd_pipe #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .BURST_W (BURST_W)
  ) i_pipe (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .we_n      (we_n),
    .adv_ld    (adv_ld),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .linear    (burst_lin),
    .bsel_n    (bsel_n),
    .addr      (addr),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .s2_bsel_n (s2_bsel_n)
  );

  zt_lane_ram #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_ram (
    .clk     (clk),
    .en      (en),
    .rd_addr (s1_addr),
    .rd_q    (ram_q),
    .wr_en   (wr_now),
    .wr_addr (s2_addr),
    .wr_lane (~s2_bsel_n),
    .wr_data (wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_vld  <= 1'b0;
      fw_addr <= '0;
      fw_lane <= '0;
      fw_data <= '0;
    end else if (wr_now) begin
      fw_vld  <= 1'b1;
      fw_addr <= s2_addr;
      fw_lane <= ~s2_bsel_n;
      fw_data <= wdata;
    end
  end

  assign fw_hit = fw_vld && (fw_addr == s2_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g] = (fw_hit && fw_lane[g]) ? fw_data[g] : ram_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
      out_q <= '0;
    end else if (en) begin
      drv_q <= (s2_op == OP_RD);
      if (s2_op == OP_RD) out_q <= merged;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = drv_q && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
  import zt_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cken_n,
  input logic              oe_n,
  input logic              adv_ld,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  logic past_ok = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R7
  oe_block_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cken_n)) |-> ($stable(dq_out) && $stable(s1_op) && $stable(s2_op)));

  // R8
  wr_phase_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && s2_op == OP_WR) |=> !dq_oe);

  // R5
  desel_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> (s1_op == OP_IDLE));

  // R10
  adv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && adv_ld && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cken_n && s2_op == OP_RD) |=> (oe_n || dq_oe));
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .cken_n (cken_n),
  .oe_n   (oe_n),
  .adv_ld (adv_ld),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .s1_op  (s1_op),
  .s2_op  (s2_op),
  .dq_out (dq_out),
  .dq_oe  (dq_oe)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  localparam int M_IDLE = 0;
  localparam int M_RD   = 1;
  localparam int M_WR   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we_n = 1'b1;
  logic [NL-1:0] bsel_n = '1;
  logic          adv_ld = 1'b0;
  logic          ce1_n = 1'b1;
  logic          ce2 = 1'b0;
  logic          ce3_n = 1'b1;
  logic          cken_n = 1'b0;
  logic          oe_n = 1'b0;
  logic          burst_lin = 1'b1;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [DW-1:0] ref_mem [DEPTH];
  int            m1_op, m2_op;
  logic [AW-1:0] m1_addr, m2_addr;
  logic [NL-1:0] m1_bs, m2_bs;
  logic [AW-1:0] mb_base;
  logic [1:0]    mb_cnt;
  bit            exp_drv;
  logic [DW-1:0] exp_out;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_W(2)) i_zt_sram (
    .clk(clk), .rst(rst), .addr(addr), .we_n(we_n), .bsel_n(bsel_n),
    .adv_ld(adv_ld), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .cken_n(cken_n), .oe_n(oe_n), .burst_lin(burst_lin),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge.
  // dk: 0 selected, 1 ce1_n high, 2 ce2 low, 3 ce3_n high.
  task automatic step(input bit en, input int dk, input bit wr, input bit adv,
                      input logic [NL-1:0] bs, input logic [AW-1:0] a,
                      input bit oe, input string tag);
    logic [63:0]   r;
    int            nop;
    logic [AW-1:0] na;
    r = {$urandom(), $urandom()};
    cken_n = !en; we_n = !wr; adv_ld = adv; bsel_n = bs; addr = a; oe_n = !oe;
    ce1_n = (dk == 1); ce2 = (dk != 2); ce3_n = (dk == 3);
    dq_in = r[DW-1:0];
    @(posedge clk);
    if (en) begin
      if (m2_op == M_RD) begin exp_out = ref_mem[m2_addr]; exp_drv = 1'b1; end
      else exp_drv = 1'b0;
      if (m2_op == M_WR)
        for (int l = 0; l < NL; l++)
          if (!m2_bs[l]) ref_mem[m2_addr][l*LW +: LW] = dq_in[l*LW +: LW];
      na = m1_addr;
      nop = M_IDLE;
      if (!adv) begin
        if (dk == 0) begin
          nop = wr ? M_WR : M_RD; mb_base = a; mb_cnt = 2'd0; na = a;
        end
      end else if (m1_op != M_IDLE) begin
        nop = m1_op;
        mb_cnt = mb_cnt + 2'd1;
        na = {mb_base[AW-1:2], burst_lin ? 2'(mb_base[1:0] + mb_cnt) : (mb_base[1:0] ^ mb_cnt)};
      end
      m2_op = m1_op; m2_addr = m1_addr; m2_bs = m1_bs;
      m1_op = nop; m1_addr = na; m1_bs = bs;
    end
    @(negedge clk);
    chk(dq_oe == (exp_drv && oe), {tag, " drive"}, {35'd0, dq_oe}, {35'd0, exp_drv && oe});
    if (exp_drv && oe) chk(dq_out === exp_out, {tag, " data"}, dq_out, exp_out);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, 0, 0, '1, a, 1, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bs, input string tag);
    step(1, 0, 1, 0, bs, a, 1, tag);
  endtask
  task automatic nop(input string tag);
    step(1, 1, 0, 0, '1, '0, 1, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1; oe_n = 1'b0; cken_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dq_oe == 1'b0, "R1 in reset", {35'd0, dq_oe}, '0);
    rst = 1'b0;
    m1_op = M_IDLE; m2_op = M_IDLE; exp_drv = 1'b0;
    m1_bs = '1; m2_bs = '1; m1_addr = '0; m2_addr = '0; mb_base = '0; mb_cnt = '0;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R1 after reset", {35'd0, dq_oe}, '0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), '0, "R3 fill");
    nop("R3"); nop("R3");
  endtask

  task automatic t_latency;
    rd(6'd3, "R2 cmd"); nop("R2 wait"); nop("R2 data"); nop("R2 after");
    wr(6'd4, '0, "R3 cmd"); nop("R3"); nop("R3 data"); rd(6'd4, "R3 read");
    nop("R3"); nop("R3 check");
  endtask

  task automatic t_lanes;
    wr(6'd7, 4'b1010, "R4 partial"); nop("R4"); nop("R4"); nop("R4");
    rd(6'd7, "R4"); nop("R4"); nop("R4 merged");
    wr(6'd8, 4'b1111, "R4 none"); nop("R4"); nop("R4"); rd(6'd8, "R4");
    nop("R4"); nop("R4 unchanged");
  endtask

  task automatic t_desel;
    for (int k = 1; k < 4; k++) begin
      step(1, k, 1, 0, '0, 6'd9, 1, "R5 ignored write");
      nop("R8 desel"); nop("R8 desel");
      rd(6'd9, "R5 read"); nop("R5"); nop("R5 old data");
    end
    rd(6'd10, "R8"); nop("R8 off after desel"); nop("R8"); nop("R8");
  endtask

  task automatic t_stall;
    rd(6'd10, "R6");
    for (int k = 0; k < 3; k++) step(0, 0, 1, 0, '0, 6'd10, 1, "R6 stall");
    nop("R6"); nop("R6 data after stall");
    for (int k = 0; k < 3; k++) step(0, 0, 1, 0, '0, 6'd10, 1, "R6 hold");
    rd(6'd10, "R6 unchanged"); nop("R6"); nop("R6 no write");
  endtask

  task automatic t_oe;
    rd(6'd11, "R7"); nop("R7");
    step(1, 1, 0, 0, '1, '0, 0, "R7 oe high");
    rd(6'd11, "R7"); nop("R7");
    step(1, 1, 0, 0, '1, '0, 1, "R7 oe low");
  endtask

  task automatic t_b2b;
    wr(6'd20, '0, "R9"); rd(6'd20, "R9"); wr(6'd20, 4'b1100, "R9 partial");
    rd(6'd20, "R9 fwd"); rd(6'd20, "R9"); wr(6'd21, 4'b0110, "R9");
    rd(6'd21, "R9 fwd"); wr(6'd20, 4'b0011, "R9"); rd(6'd20, "R9 merge");
    nop("R9"); nop("R9"); nop("R9");
  endtask

  task automatic t_burst;
    burst_lin = 1'b1;
    wr(6'd29, '0, "R10 lin");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, '0, '0, 1, "R10 lin adv");
    rd(6'd29, "R10 lin");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, '1, '0, 1, "R10 lin adv");
    nop("R10"); nop("R10"); nop("R10");
    burst_lin = 1'b0;
    wr(6'd45, '0, "R10 ilv");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, '0, '0, 1, "R10 ilv adv");
    rd(6'd45, "R10 ilv");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, '1, '0, 1, "R10 ilv adv");
    nop("R10");
    step(1, 0, 1, 1, '0, '0, 1, "R10 adv after desel");
    nop("R10"); nop("R10");
    burst_lin = 1'b1;
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      step(sel != 0, (sel == 1) ? 2 : 0, $urandom_range(0, 1), (sel == 2),
           NL'($urandom()), AW'($urandom()), $urandom_range(0, 7) != 0, "R9 random");
    end
    nop("R9"); nop("R9"); nop("R9");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_fill;
    t_latency;
    t_lanes;
    t_desel;
    t_stall;
    t_oe;
    t_b2b;
    t_burst;
    t_random;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule